// File: doc/BRIEF.md
# Peripheral Bus Clock Divider

This block makes a peripheral bus clock from a faster input clock by an integer ratio of 1 to 128. Software programs the ratio through a small register port. A new ratio is not applied at once. It is held as pending and loaded at the end of the output period in progress, so the output never shows a shortened period while the ratio changes. A ready flag in the same register stays low while a change is pending, and software polls it before and after each change.

An enable bit gates the divided clock. Software changes it with a plain write, or with separate set and clear operations that leave the rest of the register alone. The gate only switches while the output is low, and only on the falling edge of the input clock. This means no pulse is ever cut short or started part-way. A ratio write takes effect only while the system key input reports the lock as open. This guards the clock tree against stray writes.

Top module: `pbclk_div`

## Requirements
- R1: The divisor equals the 7-bit ratio field (register bits 6:0) plus one, which gives 1 to 128. After reset the field is 0 and the divisor is 1.
- R2: For a divisor N of 2 or more, the output period is N input cycles: high for floor(N/2) cycles and low for the remaining ceil(N/2) cycles. For odd N the high phase is one cycle shorter.
- R3: With the field at 0 and the output enabled, the output follows the input clock.
- R4: `reg_op` selects the operation. 0 is a plain write: bit 15 loads the enable and bits 6:0 carry a new ratio. 1 is set: a 1 in data bit 15 sets the enable. 2 is clear: a 1 in data bit 15 clears the enable. 3 has no effect. Set and clear never change the ratio field.
- R5: A plain write carries a new ratio only while `key_open` is high. When `key_open` is low, the field and ready flag are unchanged, and bit 15 is still written to the enable.
- R6: Ready (bit 11) reads 0 in the cycle after an accepted ratio write. It returns to 1 when the new ratio is loaded, which happens at the end of the output period in progress, within the old divisor's count of input cycles.
- R7: Bits 6:0 read back the ratio in use. While a change is pending they still show the old value, and they change only when a pending ratio is loaded.
- R8: While the enable (bit 15) is 0, the output is held low. The gate switches only on a falling input edge while the output is low, so every high pulse has its full length.
- R9: After reset, the enable reads 0, ready reads 1, the field reads 0 and the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input (system) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_open | input | 1 | System lock open; allows a ratio change |
| reg_wr | input | 1 | Register access strobe |
| reg_op | input | 2 | 0 write, 1 set, 2 clear, 3 none |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Bit 15 enable, bit 11 ready, bits 6:0 ratio in use |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
The assertions check the register behaviour on every cycle:
- ready drops after an accepted ratio write;
- the field holds while no change is pending;
- set and clear act on the enable;
- a locked write leaves ratio and ready untouched;
- the output never rises while the enable was off.

The remaining behaviour is shown only by the bench's scenarios:
- the high and low phase lengths for each divisor;
- pass-through at divisor 1;
- load latency bounded by the old period;
- full-length pulses while the enable is toggled at varying offsets.

// File: rtl/pbclk_div.sv
module pbclk_div #(
  parameter int DIV_W = 7,
  parameter logic [DIV_W-1:0] RST_FIELD = '0
) (
  input  logic        clk_in,
  input  logic        rst_n,
  input  logic        key_open,
  input  logic        reg_wr,
  input  logic [1:0]  reg_op,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        clk_out
);
  localparam int EN_BIT  = 15;
  localparam int RDY_BIT = 11;
  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_SET = 2'd1;
  localparam logic [1:0] OP_CLR = 2'd2;

  logic [DIV_W-1:0] act_f, pend_f, cnt;
  logic             pend, en_q, ph, gate;

  wire wr_plain = reg_wr && (reg_op == OP_WR);
  wire div_acc  = wr_plain && key_open;
  wire at_end   = (cnt == act_f);
  wire load     = at_end && pend && !div_acc;
  wire byp      = (act_f == '0);

  wire [DIV_W-1:0] nxt_f   = load ? pend_f : act_f;
  wire [DIV_W-1:0] nxt_cnt = at_end ? '0 : cnt + 1'b1;
  wire [DIV_W:0]   nxt_half = ({1'b0, nxt_f} + 1'b1) >> 1;

  wire unused_bits = ^reg_wdata[14:DIV_W];

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      act_f  <= RST_FIELD;
      ph     <= (RST_FIELD != '0);
    end else begin
      cnt    <= nxt_cnt;
      act_f  <= nxt_f;
      ph     <= ({1'b0, nxt_cnt} < nxt_half);
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      pend_f <= RST_FIELD;
    end else if (div_acc) begin
      pend   <= 1'b1;
      pend_f <= reg_wdata[DIV_W-1:0];
    end else if (load) begin
      pend   <= 1'b0;
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)
      en_q <= 1'b0;
    else if (reg_wr) begin
      case (reg_op)
        OP_WR:   en_q <= reg_wdata[EN_BIT];
        OP_SET:  if (reg_wdata[EN_BIT]) en_q <= 1'b1;
        OP_CLR:  if (reg_wdata[EN_BIT]) en_q <= 1'b0;
        default: en_q <= en_q;
      endcase
    end
  end

  // gate moves only on a falling input edge while the output is low
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n)
      gate <= 1'b0;
    else if (byp || !ph)
      gate <= en_q;
  end

  assign clk_out = gate & (byp ? clk_in : ph);

  always_comb begin
    reg_rdata               = '0;
    reg_rdata[EN_BIT]       = en_q;
    reg_rdata[RDY_BIT]      = !pend;
    reg_rdata[DIV_W-1:0]    = act_f;
  end
endmodule

// File: rtl/pbclk_div_chk.sv
module pbclk_div_chk #(
  parameter int DIV_W = 7
) (
  input logic        clk_in,
  input logic        rst_n,
  input logic        key_open,
  input logic        reg_wr,
  input logic [1:0]  reg_op,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        clk_out
);
  assert_rdy_drop_R6: assert property (@(posedge clk_in) disable iff (!rst_n)
    (reg_wr && reg_op == 2'd0 && key_open) |=> !reg_rdata[11]);

  assert_field_hold_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
    (reg_rdata[11] && !(reg_wr && reg_op == 2'd0 && key_open))
      |=> $stable(reg_rdata[DIV_W-1:0]));

  assert_set_en_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
    (reg_wr && reg_op == 2'd1 && reg_wdata[15]) |=> reg_rdata[15]);

  assert_clr_en_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
    (reg_wr && reg_op == 2'd2 && reg_wdata[15]) |=> !reg_rdata[15]);

  assert_locked_write_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
    (reg_wr && reg_op == 2'd0 && !key_open && reg_rdata[11])
      |=> (reg_rdata[11] && $stable(reg_rdata[DIV_W-1:0])));

  assert_no_rise_off_R8: assert property (@(negedge clk_in) disable iff (!rst_n)
    $rose(clk_out) |-> $past(reg_rdata[15]));
endmodule

bind pbclk_div pbclk_div_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .key_open(key_open), .reg_wr(reg_wr),
  .reg_op(reg_op), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_out(clk_out)
);

// File: tb/sim_pbclk_div.sv
module sim_pbclk_div;
  logic        clk_in = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_open = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_op = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  wire  [15:0] reg_rdata;
  wire         clk_out;

  always #5 clk_in = ~clk_in;

  pbclk_div u0 (
    .clk_in(clk_in), .rst_n(rst_n), .key_open(key_open), .reg_wr(reg_wr),
    .reg_op(reg_op), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_out(clk_out)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  bit mon_on = 1'b0, armed = 1'b0;
  int mon_half = 0, run = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_hi(input int n); return n / 2; endfunction
  function automatic int exp_lo(input int n); return n - n / 2; endfunction

  task automatic reg_access(input logic [1:0] op, input logic [15:0] d);
    @(negedge clk_in);
    reg_wr = 1'b1; reg_op = op; reg_wdata = d;
    @(negedge clk_in);
    reg_wr = 1'b0; reg_op = 2'd0; reg_wdata = 16'd0;
  endtask

  task automatic set_div(input int n);
    int old, lat;
    old = int'(reg_rdata[6:0]);
    key_open = 1'b1;
    reg_access(2'd0, 16'h8000 | 16'(n - 1));
    key_open = 1'b0;
    chk(reg_rdata[11] == 1'b0, "R6", "ready after write", int'(reg_rdata[11]), 0);
    chk(int'(reg_rdata[6:0]) == old, "R7", "field while pending", int'(reg_rdata[6:0]), old);
    lat = 0;
    while (!reg_rdata[11] && lat < 1000) begin
      @(negedge clk_in); lat++;
    end
    chk(lat >= 1 && lat <= old + 1, "R6", "load latency", lat, old + 1);
    chk(int'(reg_rdata[6:0]) == n - 1, "R1", "field after load", int'(reg_rdata[6:0]), n - 1);
  endtask

  task automatic measure(input int n);
    int guard, hi, lo;
    bit p, s;
    if (n == 1) begin
      for (int i = 0; i < 3; i++) begin
        @(posedge clk_in); #1;
        chk(clk_out == 1'b1, "R3", "pass-through high", int'(clk_out), 1);
        @(negedge clk_in); #1;
        chk(clk_out == 1'b0, "R3", "pass-through low", int'(clk_out), 0);
      end
    end else begin
      @(posedge clk_in); #1; p = clk_out;
      guard = 0;
      while (guard < 600) begin
        @(posedge clk_in); #1; s = clk_out;
        if (!p && s) break;
        p = s; guard++;
      end
      hi = 1;
      @(posedge clk_in); #1;
      while (clk_out && hi < 300) begin hi++; @(posedge clk_in); #1; end
      lo = 1;
      @(posedge clk_in); #1;
      while (!clk_out && lo < 300) begin lo++; @(posedge clk_in); #1; end
      chk(hi == exp_hi(n), "R2", $sformatf("high phase N=%0d", n), hi, exp_hi(n));
      chk(lo == exp_lo(n), "R2", $sformatf("low phase N=%0d", n), lo, exp_lo(n));
    end
  endtask

  // pulse width monitor for R8
  always @(posedge clk_in) begin
    #2;
    if (!mon_on) begin
      armed = 1'b0; run = 0;
    end else if (!clk_out) begin
      if (armed && run > 0)
        chk(run == mon_half, "R8", "high pulse length", run, mon_half);
      run = 0; armed = 1'b1;
    end else if (armed) begin
      run++;
    end
  end

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_in);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int seed_dummy;
    int n, f0;
    seed_dummy = $urandom(32'd4711);
    repeat (3) @(negedge clk_in);
    rst_n = 1'b1;
    @(negedge clk_in);
    // R9 reset state
    chk(reg_rdata[15] == 1'b0, "R9", "enable after reset", int'(reg_rdata[15]), 0);
    chk(reg_rdata[11] == 1'b1, "R9", "ready after reset", int'(reg_rdata[11]), 1);
    chk(reg_rdata[6:0] == 7'd0, "R9", "field after reset", int'(reg_rdata[6:0]), 0);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_in); #1;
      chk(clk_out == 1'b0, "R9", "output after reset", int'(clk_out), 0);
    end

    // directed ratios
    set_div(1);   measure(1);
    set_div(2);   measure(2);
    set_div(3);   measure(3);
    set_div(128); measure(128);
    set_div(127); measure(127);
    set_div(1);   measure(1);

    // R5 locked write
    f0 = int'(reg_rdata[6:0]);
    key_open = 1'b0;
    reg_access(2'd0, 16'h8000 | 16'h0033);
    chk(reg_rdata[11] == 1'b1, "R5", "ready after locked write", int'(reg_rdata[11]), 1);
    chk(int'(reg_rdata[6:0]) == f0, "R5", "field after locked write", int'(reg_rdata[6:0]), f0);
    repeat (5) @(negedge clk_in);
    chk(int'(reg_rdata[6:0]) == f0, "R5", "field later", int'(reg_rdata[6:0]), f0);
    reg_access(2'd0, 16'h0000);
    chk(reg_rdata[15] == 1'b0, "R5", "enable written while locked", int'(reg_rdata[15]), 0);
    reg_access(2'd1, 16'h8000);

    // R4 op 3 and clear without bit 15
    reg_access(2'd3, 16'h0000);
    chk(reg_rdata[15] == 1'b1, "R4", "op 3 no effect", int'(reg_rdata[15]), 1);
    reg_access(2'd2, 16'h007F);
    chk(reg_rdata[15] == 1'b1, "R4", "clear without bit 15", int'(reg_rdata[15]), 1);
    chk(int'(reg_rdata[6:0]) == f0, "R4", "clear keeps field", int'(reg_rdata[6:0]), f0);

    // R8 bypass gating
    reg_access(2'd2, 16'h8000);
    @(negedge clk_in);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_in); #1;
      chk(clk_out == 1'b0, "R8", "bypass gated off", int'(clk_out), 0);
    end

    // R8 gating in divider mode with full pulses
    reg_access(2'd1, 16'h8000);
    set_div(5);
    mon_half = exp_hi(5);
    mon_on = 1'b1;
    reg_access(2'd2, 16'h8000 | 16'h0011);
    chk(int'(reg_rdata[6:0]) == 4, "R4", "clear keeps field", int'(reg_rdata[6:0]), 4);
    repeat (8) @(negedge clk_in);
    for (int i = 0; i < 10; i++) begin
      @(posedge clk_in); #1;
      chk(clk_out == 1'b0, "R8", "divided gated off", int'(clk_out), 0);
    end
    reg_access(2'd1, 16'h8000 | 16'h0022);
    chk(int'(reg_rdata[6:0]) == 4, "R4", "set keeps field", int'(reg_rdata[6:0]), 4);
    for (int k = 0; k < 7; k++) begin
      reg_access(2'd2, 16'h8000);
      repeat (k) @(negedge clk_in);
      reg_access(2'd1, 16'h8000);
      repeat (k + 3) @(negedge clk_in);
    end
    repeat (12) @(negedge clk_in);
    mon_on = 1'b0;
    measure(5);

    // random ratios
    for (int i = 0; i < 16; i++) begin
      n = int'($urandom_range(128, 1));
      set_div(n);
      measure(n);
    end

    summary();
  end
endmodule